// File: doc/BRIEF.md
# Pipeline hazard controller

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) keeps its results correct when instructions overlap. It looks at the register numbers that the decode and execute instructions read. It also looks at the destination register, write enable and load flag of the older instructions further down the pipe, and at the outcome of a branch being resolved in execute. From these it produces four controls:

- Two operand-forwarding selects, one per ALU input.
- A stall that holds the program counter and the fetch/decode register.
- A bubble that clears the decode/execute register.
- A flush that squashes the instruction fetched down the not-taken path.

Forwarding removes most read-after-write waits. A value loaded from memory exists only after the memory stage, so an instruction that uses it straight after the load is held for one cycle. Branches are predicted not taken. When a branch turns out taken, the younger instructions are dropped.

A three-state controller remembers what the pipe did in the previous cycle. Its states are:

- ST_RUN: normal operation.
- ST_HOLD: a stall was issued in the previous cycle.
- ST_SQUASH: a flush was issued in the previous cycle.

It has five transitions:

- ST_RUN to ST_SQUASH on a taken branch.
- ST_RUN to ST_HOLD on a load-use hazard.
- ST_RUN to ST_RUN otherwise.
- ST_HOLD to ST_RUN unconditionally.
- ST_SQUASH to ST_RUN unconditionally.

In ST_HOLD and ST_SQUASH the execute stage holds the bubble that was just inserted, so its load and branch status is not acted on.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: An ALU input selects the memory-stage result (select code 2'b10) when its execute source register is non-zero and equals the destination of a memory-stage instruction that writes and is not a load.
- R2: When R1 does not apply, an ALU input selects the writeback value (code 2'b01) if its non-zero source equals the writeback destination with write enable high; a qualifying memory-stage match always wins over a writeback match.
- R3: Otherwise an ALU input takes the register file value (code 2'b00); register 0 never produces a forwarding select, a stall or any other hazard action.
- R4: In ST_RUN, a writing load in execute whose non-zero destination equals a valid decode source raises stall and bubble for one cycle with flush low.
- R5: A decode source whose valid bit is low, or an execute producer that is not a load or does not write, never raises a stall.
- R6: In the cycle after a stall or a flush (states ST_HOLD and ST_SQUASH), the execute-stage load and branch inputs are ignored: stall, flush and bubble stay low.
- R7: In ST_RUN, branch resolve and branch taken both high raise flush and bubble with stall low, even when a load-use hazard is present at the same time. Resolve without taken, or taken without resolve, raises nothing.
- R8: Reset places the controller in ST_RUN; with idle stage inputs every output is low and all forwarding selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_src | input | NUM_SRC x REG_AW | Source register numbers of the decode instruction |
| id_src_vld | input | NUM_SRC | Decode instruction actually reads the matching source |
| ex_src | input | NUM_SRC x REG_AW | Source register numbers of the execute instruction |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_AW | Destination register of the writeback instruction |
| wb_we | input | 1 | Writeback instruction writes a register |
| br_resolve | input | 1 | A branch in execute resolves this cycle |
| br_taken | input | 1 | The resolving branch is taken |
| fwd_sel | output | NUM_SRC x 2 | Per-ALU-input operand select |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Clear the decode/execute register |
| flush | output | 1 | Squash the fetch/decode register contents |

## Verification
The embedded properties watch, on every cycle, three things. No stall or flush follows directly after a bubble was inserted. A flush always overrides a stall. A forwarding select never names a memory-stage load or register 0. The priority between memory and writeback matches, and the suppression of stale execute status after ST_HOLD and ST_SQUASH, depend on particular input combinations. Only the bench's directed corner cases and its reference model over random stage contents can show that these give the exact expected code values.

// File: rtl/phc_pkg.sv
package phc_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_HOLD   = 2'b01,
        ST_SQUASH = 2'b10
    } ctl_state_e;

endpackage

// File: rtl/phc_fwd_select.sv
module phc_fwd_select
    import phc_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_we,
    input  logic              mem_is_load,
    input  logic [REG_AW-1:0] wb_rd,
    input  logic              wb_we,
    output fwd_sel_e          sel
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic src_live;
    logic mem_hit;
    logic wb_hit;

    // Register 0 is hard-wired; it never takes part in forwarding.
    assign src_live = (src != ZERO_REG);

    // A load in the memory stage only has its address, not its data.
    assign mem_hit = src_live && mem_we && !mem_is_load && (mem_rd == src);
    assign wb_hit  = src_live && wb_we && (wb_rd == src);

    // The younger producer (memory stage) has priority.
    always_comb begin
        if (mem_hit) begin
            sel = FWD_MEM;
        end else if (wb_hit) begin
            sel = FWD_WB;
        end else begin
            sel = FWD_RF;
        end
    end

    p_mem_not_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_MEM) |-> (mem_we && !mem_is_load && mem_rd == src));

    p_wb_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_WB) |-> (wb_we && wb_rd == src));

    p_zero_reg_rf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ZERO_REG) |-> (sel == FWD_RF));

endmodule

// File: rtl/phc_load_use.sv
module phc_load_use #(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input  logic [NUM_SRC-1:0]             id_src_vld,
    input  logic [REG_AW-1:0]              ex_rd,
    input  logic                           ex_we,
    input  logic                           ex_is_load,
    output logic                           hazard
);

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic                 load_pending;
    logic [NUM_SRC-1:0]   src_match;

    // Only a writing load to a real register can leave its consumer short.
    assign load_pending = ex_is_load && ex_we && (ex_rd != ZERO_REG);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_match[g] = load_pending && id_src_vld[g] && (id_src[g] == ex_rd);
    end

    assign hazard = |src_match;

    p_load_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> (ex_is_load && ex_we));

    p_no_zero_hazard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> (ex_rd != ZERO_REG));

    p_valid_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_src_vld == '0) |-> !hazard);

endmodule

// File: rtl/phc_ctrl_fsm.sv
module phc_ctrl_fsm
    import phc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_use,
    input  logic br_resolve,
    input  logic br_taken,
    output logic stall,
    output logic bubble,
    output logic flush
);

    ctl_state_e state;
    ctl_state_e state_nx;
    logic       redirect;

    assign redirect = br_resolve && br_taken;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = ST_RUN;
        unique case (state)
            ST_RUN: begin
                if (redirect) begin
                    state_nx = ST_SQUASH;
                end else if (load_use) begin
                    state_nx = ST_HOLD;
                end else begin
                    state_nx = ST_RUN;
                end
            end
            ST_HOLD:   state_nx = ST_RUN;
            ST_SQUASH: state_nx = ST_RUN;
            default:   state_nx = ST_RUN;
        endcase
    end

    // Output logic: execute holds a fresh bubble in ST_HOLD / ST_SQUASH.
    always_comb begin
        stall  = 1'b0;
        flush  = 1'b0;
        bubble = 1'b0;
        unique case (state)
            ST_RUN: begin
                flush  = redirect;
                stall  = load_use && !redirect;
                bubble = redirect || load_use;
            end
            ST_HOLD:   ;
            ST_SQUASH: ;
            default:   ;
        endcase
    end

    p_single_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || flush) |=> !(stall || flush || bubble));

    p_flush_beats_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!stall && bubble));

    p_stall_bubbles_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (bubble && !flush && load_use));

    p_redirect_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && redirect) |-> flush);

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import phc_pkg::*;
#(
    parameter int REG_AW  = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] id_src,
    input  logic [NUM_SRC-1:0]             id_src_vld,
    input  logic [NUM_SRC-1:0][REG_AW-1:0] ex_src,
    input  logic [REG_AW-1:0]              ex_rd,
    input  logic                           ex_we,
    input  logic                           ex_is_load,
    input  logic [REG_AW-1:0]              mem_rd,
    input  logic                           mem_we,
    input  logic                           mem_is_load,
    input  logic [REG_AW-1:0]              wb_rd,
    input  logic                           wb_we,
    input  logic                           br_resolve,
    input  logic                           br_taken,
    output logic [NUM_SRC-1:0][1:0]        fwd_sel,
    output logic                           stall,
    output logic                           bubble,
    output logic                           flush
);

    logic load_use;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
        fwd_sel_e sel_w;

        phc_fwd_select #(
            .REG_AW (REG_AW)
        ) u_fwd (
            .clk         (clk),
            .rst_n       (rst_n),
            .src         (ex_src[g]),
            .mem_rd      (mem_rd),
            .mem_we      (mem_we),
            .mem_is_load (mem_is_load),
            .wb_rd       (wb_rd),
            .wb_we       (wb_we),
            .sel         (sel_w)
        );

        assign fwd_sel[g] = sel_w;
    end

    phc_load_use #(
        .REG_AW  (REG_AW),
        .NUM_SRC (NUM_SRC)
    ) u_load_use (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_src     (id_src),
        .id_src_vld (id_src_vld),
        .ex_rd      (ex_rd),
        .ex_we      (ex_we),
        .ex_is_load (ex_is_load),
        .hazard     (load_use)
    );

    phc_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_use   (load_use),
        .br_resolve (br_resolve),
        .br_taken   (br_taken),
        .stall      (stall),
        .bubble     (bubble),
        .flush      (flush)
    );

endmodule

// File: tb/pipe_hazard_ctl_test.sv
`timescale 1ns/1ps
module pipe_hazard_ctl_test;

    localparam int RW = 5;
    localparam int NS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0][RW-1:0] id_src = '0;
    logic [NS-1:0]         id_src_vld = '0;
    logic [NS-1:0][RW-1:0] ex_src = '0;
    logic [RW-1:0]         ex_rd = '0;
    logic                  ex_we = 1'b0;
    logic                  ex_is_load = 1'b0;
    logic [RW-1:0]         mem_rd = '0;
    logic                  mem_we = 1'b0;
    logic                  mem_is_load = 1'b0;
    logic [RW-1:0]         wb_rd = '0;
    logic                  wb_we = 1'b0;
    logic                  br_resolve = 1'b0;
    logic                  br_taken = 1'b0;
    logic [NS-1:0][1:0]    fwd_sel;
    logic                  stall;
    logic                  bubble;
    logic                  flush;

    int checks = 0;
    int errors = 0;
    bit hold_prev = 1'b0;

    always #2.5 clk = ~clk;

    pipe_hazard_ctl #(.REG_AW(RW), .NUM_SRC(NS)) uut (
        .clk(clk), .rst_n(rst_n), .id_src(id_src), .id_src_vld(id_src_vld),
        .ex_src(ex_src), .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_is_load(mem_is_load),
        .wb_rd(wb_rd), .wb_we(wb_we), .br_resolve(br_resolve), .br_taken(br_taken),
        .fwd_sel(fwd_sel), .stall(stall), .bubble(bubble), .flush(flush)
    );

    // Reference select per R1..R3
    function automatic logic [1:0] ref_sel(logic [RW-1:0] s);
        if (s != 0 && mem_we && !mem_is_load && mem_rd == s) return 2'b10;
        if (s != 0 && wb_we && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    // Reference load-use per R4/R5
    function automatic bit ref_load_use();
        bit hit = 1'b0;
        for (int i = 0; i < NS; i++) begin
            if (ex_is_load && ex_we && ex_rd != 0 && id_src_vld[i] && id_src[i] == ex_rd)
                hit = 1'b1;
        end
        return hit;
    endfunction

    task automatic chk(string tag, string what, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_cycle(string force_tag = "");
        bit e_flush, e_stall, e_bub;
        string ts, tf, tg;
        #1;
        e_flush = !hold_prev && br_resolve && br_taken;
        e_stall = !hold_prev && !e_flush && ref_load_use();
        e_bub   = e_stall || e_flush;
        ts = e_stall ? "R4" : (hold_prev ? "R6" : (e_flush ? "R7" : "R5"));
        tf = e_flush ? "R7" : (hold_prev ? "R6" : "R7");
        if (force_tag != "") begin
            ts = force_tag;
            tf = force_tag;
        end
        chk(ts, "stall", {1'b0, stall}, {1'b0, e_stall});
        chk(tf, "flush", {1'b0, flush}, {1'b0, e_flush});
        chk(ts, "bubble", {1'b0, bubble}, {1'b0, e_bub});
        for (int i = 0; i < NS; i++) begin
            logic [1:0] es;
            es = ref_sel(ex_src[i]);
            tg = (force_tag != "") ? force_tag : (es == 2'b10 ? "R1" : (es == 2'b01 ? "R2" : "R3"));
            chk(tg, "fwd_sel", fwd_sel[i], es);
        end
        @(posedge clk);
        hold_prev = rst_n && e_bub;
        @(negedge clk);
    endtask

    task automatic idle();
        id_src = '0; id_src_vld = '0; ex_src = '0;
        ex_rd = '0; ex_we = 0; ex_is_load = 0;
        mem_rd = '0; mem_we = 0; mem_is_load = 0;
        wb_rd = '0; wb_we = 0; br_resolve = 0; br_taken = 0;
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        @(negedge clk);
        @(negedge clk);
        run_cycle("R8");               // reset state, idle inputs
        rst_n = 1'b1;
        @(negedge clk);
        run_cycle("R8");               // first active cycle in ST_RUN

        // R1: memory-stage forward on operand 0
        idle(); ex_src[0] = 5'd3; mem_rd = 5'd3; mem_we = 1; run_cycle();
        // R2: both match, memory wins
        wb_rd = 5'd3; wb_we = 1; run_cycle();
        // R2: memory stage is a load -> writeback value
        mem_is_load = 1; run_cycle();
        // R2: writeback only on operand 1
        idle(); ex_src[1] = 5'd7; wb_rd = 5'd7; wb_we = 1; run_cycle();
        // R3: register 0 never forwarded
        idle(); mem_rd = 0; mem_we = 1; wb_we = 1; run_cycle();
        // R3: matching register but no write enable
        idle(); ex_src[0] = 5'd9; mem_rd = 5'd9; wb_rd = 5'd9; run_cycle();

        // R4 then R6: load-use stall, same status next cycle ignored
        idle(); ex_is_load = 1; ex_we = 1; ex_rd = 5'd4;
        id_src[1] = 5'd4; id_src_vld = 2'b11; run_cycle();
        run_cycle();
        run_cycle();                   // ST_RUN again: stalls once more
        idle(); run_cycle();           // ST_HOLD cycle with idle inputs

        // R5: unused source, non-load producer, load to register 0
        ex_is_load = 1; ex_we = 1; ex_rd = 5'd4; id_src[1] = 5'd4; id_src_vld = 2'b01; run_cycle();
        id_src_vld = 2'b11; ex_is_load = 0; run_cycle();
        ex_is_load = 1; ex_rd = 0; id_src = '0; run_cycle();

        // R7: flush wins over load-use; R6: next cycle ignored
        idle(); ex_is_load = 1; ex_we = 1; ex_rd = 5'd2; id_src[0] = 5'd2; id_src_vld = 2'b01;
        br_resolve = 1; br_taken = 1; run_cycle();
        run_cycle();
        idle(); run_cycle();
        // R7: resolve without taken, taken without resolve
        br_resolve = 1; br_taken = 0; run_cycle();
        br_resolve = 0; br_taken = 1; run_cycle();

        // Random stimulus over a narrow register range
        for (int n = 0; n < 3000; n++) begin
            for (int i = 0; i < NS; i++) begin
                id_src[i] = RW'($urandom_range(0, 3));
                ex_src[i] = RW'($urandom_range(0, 3));
                id_src_vld[i] = ($urandom_range(0, 3) != 0);
            end
            ex_rd = RW'($urandom_range(0, 3));
            ex_we = $urandom_range(0, 1);
            ex_is_load = ($urandom_range(0, 2) == 0);
            mem_rd = RW'($urandom_range(0, 3));
            mem_we = $urandom_range(0, 1);
            mem_is_load = ($urandom_range(0, 2) == 0);
            wb_rd = RW'($urandom_range(0, 3));
            wb_we = $urandom_range(0, 1);
            br_resolve = ($urandom_range(0, 3) == 0);
            br_taken = $urandom_range(0, 1);
            run_cycle();
        end

        finish_up();
    end

endmodule